// File: doc/BRIEF.md
# Clock-Line Trigger Command Decoder

This block sits behind the receiver of a combined clock/command line. Most cycles on that line are plain clock cycles. Now and then a marker symbol takes the place of a plain cycle. The physical receiver has already turned each cycle into a two-bit code, and this block interprets that code stream. It keeps a timestamp counter that runs modulo 294 and a 16-bit event counter.

A synchronisation marker starts both counters from a known point and clears the error flag. A trigger marker that falls outside the check slot captures the current timestamp and event count into an event header, together with a one-cycle valid strobe. The event count then advances. The sender also places a trigger marker in slot 0 of every timestamp period. That marker acts as a consistency check and not as a trigger. If that slot passes without the marker, a sticky error flag is raised.

Downstream readout stores each header. A counter that drifts between boards can then be found later by comparing the headers.

Top module: `trig_cmd_decoder`

## Requirements
- R1: After reset, ts_o, ev_o, err_o and hdr_valid_o are all 0. The block stays idle until the first synchronisation symbol arrives. While idle, a trigger symbol produces no header and leaves ev_o at 0.
- R2: The cycle after a synchronisation symbol (sym_i = 1), ts_o is 1, ev_o is 0 and err_o is 0, whatever the previous state was. The synchronisation cycle itself occupies timestamp slot 0.
- R3: Once started, ts_o advances by one each cycle and wraps from 293 to 0.
- R4: When a trigger symbol (sym_i = 2) arrives in a cycle where ts_o is not 0, hdr_valid_o is 1 in the next cycle only. In that cycle hdr_ts_o and hdr_ev_o hold the ts_o and ev_o values of the trigger cycle.
- R5: ev_o rises by one after each header is captured, and it wraps from 65535 to 0.
- R6: A trigger symbol that arrives while ts_o is 0 (the check slot) is a check marker. It produces no header, leaves ev_o unchanged and raises no error.
- R7: If any code other than a trigger symbol arrives while ts_o is 0 after start, err_o is 1 from the next cycle on.
- R8: Code 0 is a plain clock cycle and code 3 is reserved. Outside the check slot, both leave ev_o and the header untouched.
- R9: err_o stays 1 through later correct check markers and triggers. Only a synchronisation symbol clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 2 | Decoded per-cycle code: 0 plain, 1 sync, 2 trigger/check, 3 reserved |
| ts_o | output | 9 | Current timestamp slot |
| ev_o | output | 16 | Current event count |
| err_o | output | 1 | Sticky check-slot error |
| hdr_valid_o | output | 1 | One-cycle strobe marking a new header |
| hdr_ts_o | output | 9 | Timestamp captured for the header |
| hdr_ev_o | output | 16 | Event count captured for the header |

## Verification
The bench walks the timestamp across the 293-to-0 boundary and then sends a marker in slot 0. A design that confused check markers with triggers would emit a header there and bump the count. It leaves a check slot empty with the reserved code and follows with a correct check marker. A design whose error flag is not sticky would drop the flag at that point. It drives back-to-back triggers through 65,536 events, which exposes a wrong counter width, a failed wrap, and headers that sample the count after the increment instead of before it. Markers sent before the first synchronisation show whether an unstarted block wrongly counts or captures anything.

// File: rtl/trg_pkg.sv
package trg_pkg;
    typedef enum logic [1:0] {
        SYM_CLK  = 2'd0,
        SYM_SYNC = 2'd1,
        SYM_MARK = 2'd2,
        SYM_RSVD = 2'd3
    } sym_e;
endpackage

// File: rtl/sym_classify.sv
module sym_classify
    import trg_pkg::*;
(
    input  logic [1:0] sym,
    output logic       is_sync,
    output logic       is_mark
);
    sym_e code;
    always_comb begin
        code    = sym_e'(sym);
        is_sync = (code == SYM_SYNC);
        is_mark = (code == SYM_MARK);
    end
endmodule

// File: rtl/ts_ring.sv
module ts_ring #(
    parameter int TS_MOD = 294,
    parameter int TS_W   = $clog2(TS_MOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    output logic [TS_W-1:0] ts,
    output logic            run,
    output logic            slot
);
    localparam logic [TS_W-1:0] LAST = TS_W'(TS_MOD - 1);
    localparam bit POW2 = (TS_MOD == (1 << TS_W));

    typedef struct packed {
        logic            run;
        logic [TS_W-1:0] ts;
    } st_t;

    st_t st_d, st_q;
    logic [TS_W-1:0] ts_inc;

    generate
        if (POW2) begin : g_natural_wrap
            assign ts_inc = st_q.ts + TS_W'(1);
        end else begin : g_compare_wrap
            assign ts_inc = (st_q.ts == LAST) ? '0 : st_q.ts + TS_W'(1);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (sync) begin
            st_d.run = 1'b1;
            st_d.ts  = TS_W'(1);
        end else if (st_q.run) begin
            st_d.ts = ts_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts   = st_q.ts;
    assign run  = st_q.run;
    assign slot = st_q.run && (st_q.ts == '0);
endmodule

// File: rtl/ev_header.sv
module ev_header #(
    parameter int TS_W = 9,
    parameter int EV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync,
    input  logic            trig,
    input  logic [TS_W-1:0] ts,
    output logic [EV_W-1:0] ev,
    output logic            hv,
    output logic [TS_W-1:0] hts,
    output logic [EV_W-1:0] hev
);
    typedef struct packed {
        logic [EV_W-1:0] ev;
        logic            hv;
        logic [TS_W-1:0] hts;
        logic [EV_W-1:0] hev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.hv = 1'b0;
        if (sync) begin
            st_d.ev = '0;
        end else if (trig) begin
            st_d.hv  = 1'b1;
            st_d.hts = ts;
            st_d.hev = st_q.ev;
            st_d.ev  = st_q.ev + EV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev  = st_q.ev;
    assign hv  = st_q.hv;
    assign hts = st_q.hts;
    assign hev = st_q.hev;
endmodule

// File: rtl/slot_checker.sv
module slot_checker (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    input  logic slot,
    input  logic is_mark,
    output logic err
);
    typedef struct packed {
        logic err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync)                 st_d.err = 1'b0;
        else if (slot && !is_mark) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/trig_cmd_decoder.sv
module trig_cmd_decoder #(
    parameter int TS_MOD = 294,
    parameter int TS_W   = $clog2(TS_MOD),
    parameter int EV_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      sym_i,
    output logic [TS_W-1:0] ts_o,
    output logic [EV_W-1:0] ev_o,
    output logic            err_o,
    output logic            hdr_valid_o,
    output logic [TS_W-1:0] hdr_ts_o,
    output logic [EV_W-1:0] hdr_ev_o
);
    logic is_sync, is_mark, run, slot, trig;

    sym_classify u_cls (
        .sym     (sym_i),
        .is_sync (is_sync),
        .is_mark (is_mark)
    );

    ts_ring #(.TS_MOD(TS_MOD), .TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (is_sync),
        .ts    (ts_o),
        .run   (run),
        .slot  (slot)
    );

    assign trig = is_mark && run && !slot;

    ev_header #(.TS_W(TS_W), .EV_W(EV_W)) u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (is_sync),
        .trig  (trig),
        .ts    (ts_o),
        .ev    (ev_o),
        .hv    (hdr_valid_o),
        .hts   (hdr_ts_o),
        .hev   (hdr_ev_o)
    );

    slot_checker u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (is_sync),
        .slot    (slot),
        .is_mark (is_mark),
        .err     (err_o)
    );
endmodule

// File: rtl/trg_dec_chk.sv
module trg_dec_chk #(
    parameter int TS_MOD = 294,
    parameter int TS_W   = 9,
    parameter int EV_W   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      sym_i,
    input logic [TS_W-1:0] ts_o,
    input logic [EV_W-1:0] ev_o,
    input logic            err_o,
    input logic            hdr_valid_o,
    input logic [TS_W-1:0] hdr_ts_o,
    input logic [EV_W-1:0] hdr_ev_o
);
    localparam logic [1:0] C_SYNC = 2'd1;
    localparam logic [1:0] C_MARK = 2'd2;
    localparam logic [TS_W-1:0] LAST = TS_W'(TS_MOD - 1);

    // R2
    p_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_i == C_SYNC) |=> (ts_o == TS_W'(1) && ev_o == '0 && !err_o));

    // R3
    p_ts_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_o == LAST && sym_i != C_SYNC) |=> (ts_o == '0));

    // R4
    p_hdr_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_i == C_MARK && ts_o != '0) |=> (hdr_valid_o && hdr_ts_o == $past(ts_o)));

    // R5
    p_ev_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> (ev_o == hdr_ev_o + EV_W'(1)));

    // R6
    p_check_no_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_i == C_MARK && ts_o == '0) |=> (!hdr_valid_o && $stable(ev_o)));

    // R9
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && sym_i != C_SYNC) |=> err_o);
endmodule

bind trig_cmd_decoder trg_dec_chk #(.TS_MOD(TS_MOD), .TS_W(TS_W), .EV_W(EV_W)) u_bind_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_i       (sym_i),
    .ts_o        (ts_o),
    .ev_o        (ev_o),
    .err_o       (err_o),
    .hdr_valid_o (hdr_valid_o),
    .hdr_ts_o    (hdr_ts_o),
    .hdr_ev_o    (hdr_ev_o)
);

// File: tb/tb_trig_cmd_decoder.sv
module tb_trig_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sym_i = 2'd0;
    logic [8:0]  ts_o;
    logic [15:0] ev_o;
    logic        err_o;
    logic        hdr_valid_o;
    logic [8:0]  hdr_ts_o;
    logic [15:0] hdr_ev_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_cmd_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_i       (sym_i),
        .ts_o        (ts_o),
        .ev_o        (ev_o),
        .err_o       (err_o),
        .hdr_valid_o (hdr_valid_o),
        .hdr_ts_o    (hdr_ts_o),
        .hdr_ev_o    (hdr_ev_o)
    );

    // rows: code applied, then ts, ev, hdr valid, hdr ts, hdr ev, err seen after the edge
    localparam int N = 9;
    localparam int V_SYM[N] = '{2, 1, 0, 2, 2, 3, 0, 1, 2};
    localparam int V_TS [N] = '{0, 1, 2, 3, 4, 5, 6, 1, 2};
    localparam int V_EV [N] = '{0, 0, 0, 1, 2, 2, 2, 0, 1};
    localparam int V_HV [N] = '{0, 0, 0, 1, 1, 0, 0, 0, 1};
    localparam int V_HTS[N] = '{0, 0, 0, 2, 3, 0, 0, 0, 1};
    localparam int V_HEV[N] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_ERR[N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int s);
        sym_i = 2'(s);
        @(negedge clk);
    endtask

    task automatic run_to(input int target);
        while (int'(ts_o) != target) step(0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ts", int'(ts_o), 0);
        chk("R1 ev", int'(ev_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 hv", int'(hdr_valid_o), 0);

        // table walk: idle marker R1, sync R2, triggers R4 R5, reserved R8
        for (int i = 0; i < N; i++) begin
            step(V_SYM[i]);
            chk($sformatf("R4 row%0d ts", i), int'(ts_o), V_TS[i]);
            chk($sformatf("R5 row%0d ev", i), int'(ev_o), V_EV[i]);
            chk($sformatf("R4 row%0d hv", i), int'(hdr_valid_o), V_HV[i]);
            if (V_HV[i] != 0) begin
                chk($sformatf("R4 row%0d hts", i), int'(hdr_ts_o), V_HTS[i]);
                chk($sformatf("R4 row%0d hev", i), int'(hdr_ev_o), V_HEV[i]);
            end
            chk($sformatf("R8 row%0d err", i), int'(err_o), V_ERR[i]);
        end

        // R3 wrap and R6 check slot
        step(1);
        run_to(293);
        chk("R3 top", int'(ts_o), 293);
        step(0);
        chk("R3 wrap", int'(ts_o), 0);
        step(2);
        chk("R6 ts", int'(ts_o), 1);
        chk("R6 hv", int'(hdr_valid_o), 0);
        chk("R6 ev", int'(ev_o), 0);
        chk("R6 err", int'(err_o), 0);

        // R7 missing check with reserved code (R8)
        run_to(0);
        step(3);
        chk("R7 err", int'(err_o), 1);
        chk("R8 hv", int'(hdr_valid_o), 0);
        run_to(0);
        step(2);
        chk("R9 err sticky", int'(err_o), 1);
        step(2);
        chk("R9 err after trigger", int'(err_o), 1);
        step(1);
        chk("R2 err clear", int'(err_o), 0);
        chk("R2 ev clear", int'(ev_o), 0);
        chk("R2 ts", int'(ts_o), 1);

        // R5 event counter wrap
        while (ev_o != 16'hFFFF) step(2);
        if (ts_o == 9'd0) step(2);
        step(2);
        chk("R5 hv", int'(hdr_valid_o), 1);
        chk("R5 hev", int'(hdr_ev_o), 65535);
        chk("R5 ev wrap", int'(ev_o), 0);
        chk("R6 no err on checks", int'(err_o), 0);

        finish_run();
    end
endmodule